// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block computes the data-memory address and the updated pointer for the operand moves of a DSP extension. Each request brings the current pointer value, a 2-bit addressing mode taken from the instruction word, an access-size flag, a path select (single-data move, X bus move or Y bus move) and the two index register values that the index-increment mode can use. The block returns the effective address for the access in the same cycle and registers the updated pointer on the clock edge at which the request is valid. The register file writes that value back.

On the X and Y moves a modulo wrap can replace the normal post-increment. A programmed modulo end value and delta are held in a small configuration register pair. When the pointer reaches the end value, the delta is added instead of the usual step, which lets a circular buffer wrap back to its start. The two buses detect the end value in different ways. The X side looks only at the lower half of the pointer. The Y side compares the whole end register against the pointer with its upper half forced to ones.

Top module: `modagen_top`

## Requirements
- R1: After reset `ptrOut` is 0, `ptrDone` is 0, and the modulo end and delta registers are 0.
- R2: Mode 00 on any path, and mode 01 on the X path (`pathSel`=01) or Y path (`pathSel`=10), address the pointer itself (`addrOut`=`ptrIn`) and leave the pointer unchanged.
- R3: Mode 10 is post-increment: `addrOut`=`ptrIn`, and the new pointer is `ptrIn`+4 for a single-data move (`pathSel`=00) with `sizeLong`=1, and `ptrIn`+2 otherwise. X and Y moves always step by 2, whatever `sizeLong` is.
- R4: Mode 11 is index post-increment: `addrOut`=`ptrIn`, and the new pointer is `ptrIn`+`idxX` on the single and X paths and `ptrIn`+`idxY` on the Y path.
- R5: Mode 01 on a single-data move is pre-decrement: the pointer minus 4 (`sizeLong`=1) or minus 2 (`sizeLong`=0) is both the address and the new pointer.
- R6: On an X move in mode 10 or 11, if the lower half of `ptrIn` equals the lower half of the modulo end register, the new pointer is `ptrIn` plus the modulo delta, and the step is not added.
- R7: On a Y move in mode 10 or 11, the modulo delta replaces the step exactly when `ptrIn` with its upper half forced to all ones equals the full modulo end register.
- R8: A single-data move never applies the modulo wrap, even when the pointer equals the end value.
- R9: When `cfgWe` is 1 at a clock edge, `cfgEnd` and `cfgDelta` are loaded into the modulo registers. When `cfgWe` is 0 they keep their values.
- R10: `addrOut` is combinational in the request cycle. `ptrOut` takes the new pointer at the edge where `reqValid` is 1, and `ptrDone` is 1 for the following cycle. With `reqValid` at 0, `ptrOut` holds and `ptrDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Load enable for the modulo registers |
| cfgEnd | input | ADDR_W | Modulo end value to load |
| cfgDelta | input | ADDR_W | Modulo delta to load (two's complement) |
| reqValid | input | 1 | Request strobe; registers the pointer update |
| pathSel | input | 2 | 00 single-data, 01 X bus, 10 Y bus, 11 treated as 00 |
| mode | input | 2 | Addressing mode field |
| sizeLong | input | 1 | 1 selects a 4-byte access on single-data moves |
| ptrIn | input | ADDR_W | Current pointer register value |
| idxX | input | ADDR_W | Index value for the single and X paths |
| idxY | input | ADDR_W | Index value for the Y path |
| addrOut | output | ADDR_W | Effective address of the access |
| ptrOut | output | ADDR_W | Registered updated pointer |
| ptrDone | output | 1 | One-cycle flag that `ptrOut` was updated |

## Verification
The effective address is combinational, so the bench drives each request just after a falling edge and reads `addrOut` a few nanoseconds later, before the next rising edge. The updated pointer and `ptrDone` pass through one register, so the bench reads them at the next falling edge, one rising edge after the request. A configuration write takes effect for requests that arrive after the edge that loads it. Hold checks read `ptrOut` again after an idle edge.

// File: rtl/amg_pkg.sv
package amg_pkg;

  typedef enum logic [1:0] {
    PATH_SINGLE = 2'b00,
    PATH_X      = 2'b01,
    PATH_Y      = 2'b10,
    PATH_RSVD   = 2'b11
  } path_e;

  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_DEC  = 2'b01,
    MODE_INC  = 2'b10,
    MODE_IDX  = 2'b11
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic preDec;   // subtract step, address is the reduced value
    logic postInc;  // add step (or delta) after the access
    logic useIndex; // step comes from an index register
    logic useIdxY;  // pick the Y index instead of the X index
    logic longStep; // size step is 4 instead of 2
    logic modOn;    // modulo wrap may replace the step
    logic modYCmp;  // compare with upper half forced to ones
  } amg_ctrl_t;

endpackage

// File: rtl/amg_ctrl.sv
module amg_ctrl
  import amg_pkg::*;
(
  input  logic [1:0] pathSel,
  input  logic [1:0] mode,
  input  logic       sizeLong,
  output amg_ctrl_t  ctrl
);

  logic isX;
  logic isY;
  logic isXY;

  always_comb begin
    isX  = (pathSel == PATH_X);
    isY  = (pathSel == PATH_Y);
    isXY = isX | isY;
  end

  always_comb begin
    ctrl = '0;
    unique case (mode)
      MODE_IND: begin
        ctrl = '0;
      end
      MODE_DEC: begin
        // on X/Y the field is a bus select, no pointer update
        ctrl.preDec   = !isXY;
        ctrl.longStep = !isXY & sizeLong;
      end
      MODE_INC: begin
        ctrl.postInc  = 1'b1;
        ctrl.longStep = !isXY & sizeLong;
        ctrl.modOn    = isXY;
        ctrl.modYCmp  = isY;
      end
      MODE_IDX: begin
        ctrl.postInc  = 1'b1;
        ctrl.useIndex = 1'b1;
        ctrl.useIdxY  = isY;
        ctrl.modOn    = isXY;
        ctrl.modYCmp  = isY;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/amg_datapath.sv
module amg_datapath
  import amg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgEnd,
  input  logic [ADDR_W-1:0] cfgDelta,
  input  logic              reqValid,
  input  amg_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic [ADDR_W-1:0] idxX,
  input  logic [ADDR_W-1:0] idxY,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] nextPtr,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              ptrDone
);

  localparam int HALF_W = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_LONG = ADDR_W'(4);

  logic [ADDR_W-1:0] modEnd;
  logic [ADDR_W-1:0] modDelta;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] decPtr;
  logic [ADDR_W-1:0] yView;
  logic              hitX;
  logic              hitY;
  logic              modHit;

  // modulo configuration pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modEnd   <= '0;
      modDelta <= '0;
    end else if (cfgWe) begin
      modEnd   <= cfgEnd;
      modDelta <= cfgDelta;
    end
  end

  always_comb begin
    if (ctrl.useIndex) step = ctrl.useIdxY ? idxY : idxX;
    else               step = ctrl.longStep ? STEP_LONG : STEP_WORD;
  end

  always_comb begin
    yView  = {{(ADDR_W-HALF_W){1'b1}}, ptrIn[HALF_W-1:0]};
    hitX   = (ptrIn[HALF_W-1:0] == modEnd[HALF_W-1:0]);
    hitY   = (yView == modEnd);
    modHit = ctrl.modOn & (ctrl.modYCmp ? hitY : hitX);
    decPtr = ptrIn - step;
  end

  always_comb begin
    addrOut = ctrl.preDec ? decPtr : ptrIn;
    if (ctrl.preDec)       nextPtr = decPtr;
    else if (ctrl.postInc) nextPtr = ptrIn + (modHit ? modDelta : step);
    else                   nextPtr = ptrIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrOut  <= '0;
      ptrDone <= 1'b0;
    end else begin
      ptrDone <= reqValid;
      if (reqValid) ptrOut <= nextPtr;
    end
  end

endmodule

// File: rtl/modagen_top.sv
module modagen_top
  import amg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgEnd,
  input  logic [ADDR_W-1:0] cfgDelta,
  input  logic              reqValid,
  input  logic [1:0]        pathSel,
  input  logic [1:0]        mode,
  input  logic              sizeLong,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic [ADDR_W-1:0] idxX,
  input  logic [ADDR_W-1:0] idxY,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] ptrOut,
  output logic              ptrDone
);

  amg_ctrl_t         ctrl;
  logic [ADDR_W-1:0] nextPtr;

  amg_ctrl u_ctrl (
    .pathSel (pathSel),
    .mode    (mode),
    .sizeLong(sizeLong),
    .ctrl    (ctrl)
  );

  amg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgEnd  (cfgEnd),
    .cfgDelta(cfgDelta),
    .reqValid(reqValid),
    .ctrl    (ctrl),
    .ptrIn   (ptrIn),
    .idxX    (idxX),
    .idxY    (idxY),
    .addrOut (addrOut),
    .nextPtr (nextPtr),
    .ptrOut  (ptrOut),
    .ptrDone (ptrDone)
  );

endmodule

// File: rtl/amg_chk.sv
module amg_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        pathSel,
  input logic [1:0]        mode,
  input logic              sizeLong,
  input logic [ADDR_W-1:0] ptrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [ADDR_W-1:0] nextPtr,
  input logic [ADDR_W-1:0] ptrOut,
  input logic              ptrDone
);

  // R10
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ptrDone);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(ptrOut) && !ptrDone));

  // R10
  ptr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (ptrOut == $past(nextPtr)));

  // R2
  indirect_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |-> (addrOut == ptrIn && nextPtr == ptrIn));

  // R5
  predec_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 2'b01 && pathSel == 2'b00) |=> (ptrOut == $past(addrOut)));

  // R8
  single_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel == 2'b00 && mode == 2'b10 && !sizeLong) |-> (nextPtr == ptrIn + ADDR_W'(2)));

endmodule

bind modagen_top amg_chk #(.ADDR_W(ADDR_W)) u_amg_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .pathSel (pathSel),
  .mode    (mode),
  .sizeLong(sizeLong),
  .ptrIn   (ptrIn),
  .addrOut (addrOut),
  .nextPtr (nextPtr),
  .ptrOut  (ptrOut),
  .ptrDone (ptrDone)
);

// File: tb/tb_modagen_top.sv
`timescale 1ns/1ps
module tb_modagen_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [W-1:0] cfgEnd = '0;
  logic [W-1:0] cfgDelta = '0;
  logic         reqValid = 1'b0;
  logic [1:0]   pathSel = '0;
  logic [1:0]   mode = '0;
  logic         sizeLong = 1'b0;
  logic [W-1:0] ptrIn = '0;
  logic [W-1:0] idxX = '0;
  logic [W-1:0] idxY = '0;
  logic [W-1:0] addrOut;
  logic [W-1:0] ptrOut;
  logic         ptrDone;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mEnd = '0;
  logic [W-1:0] mDelta = '0;

  always #10 clk = ~clk;

  modagen_top #(.ADDR_W(W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnd(cfgEnd), .cfgDelta(cfgDelta),
    .reqValid(reqValid), .pathSel(pathSel), .mode(mode), .sizeLong(sizeLong),
    .ptrIn(ptrIn), .idxX(idxX), .idxY(idxY),
    .addrOut(addrOut), .ptrOut(ptrOut), .ptrDone(ptrDone)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int p, input int m);
    if (m == 0) return "R2";
    if (m == 1) return (p == 0) ? "R5" : "R2";
    if (m == 2) return (p == 0) ? "R3" : "R6/R7 (R3 step)";
    return (p == 0) ? "R4" : "R6/R7 (R4 step)";
  endfunction

  // expected address and pointer from the requirements
  task automatic model(input int p, input int m, input logic lng, input logic [W-1:0] ptr,
                       output logic [W-1:0] eAddr, output logic [W-1:0] eNext);
    logic [W-1:0] stp;
    logic         hit;
    stp = (p == 0 && lng) ? 32'd4 : 32'd2;
    if (m == 3) stp = (p == 2) ? idxY : idxX;
    hit = 1'b0;
    if (p == 1) hit = (ptr[15:0] == mEnd[15:0]);
    if (p == 2) hit = ((ptr | 32'hFFFF0000) == mEnd);
    eAddr = ptr;
    eNext = ptr;
    if (m == 1 && p == 0) begin
      eAddr = ptr - stp;
      eNext = ptr - stp;
    end else if (m >= 2) begin
      eNext = ptr + (hit ? mDelta : stp);
    end
  endtask

  task automatic configure(input logic [W-1:0] e, input logic [W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgEnd = e; cfgDelta = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgEnd = 32'h5A5A5A5A; cfgDelta = 32'h12345678;
    mEnd = e; mDelta = d;
  endtask

  task automatic runOne(input int p, input int m, input logic lng, input logic [W-1:0] ptr);
    logic [W-1:0] eA;
    logic [W-1:0] eN;
    model(p, m, lng, ptr, eA, eN);
    @(negedge clk);
    reqValid = 1'b1; pathSel = 2'(p); mode = 2'(m); sizeLong = lng; ptrIn = ptr;
    #2;
    check({tagOf(p, m), " addr (R10 comb)"}, addrOut, eA);
    @(negedge clk);
    reqValid = 1'b0;
    check({tagOf(p, m), " next"}, ptrOut, eN);
    check("R10 done", {31'b0, ptrDone}, 32'd1);
  endtask

  logic [W-1:0] ptrs [4];

  initial begin
    fork
      begin
        #3000000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    idxX = 32'h00000030;
    idxY = 32'h00000104;
    #35;
    // R1 reset state
    check("R1 ptrOut", ptrOut, '0);
    check("R1 done", {31'b0, ptrDone}, '0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: zero modulo regs, X hit at low half 0 adds delta 0
    runOne(1, 2, 1'b0, 32'h12340000);
    check("R1 zero delta", ptrOut, 32'h12340000);

    ptrs[0] = 32'h00001000;
    ptrs[1] = 32'h00002000;
    ptrs[2] = 32'hABCD1000;
    ptrs[3] = 32'hFFFF0FFE;

    // config A: Y and X both able to hit
    configure(32'hFFFF1000, 32'hFFFFFF00);
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          for (int k = 0; k < 4; k++)
            runOne(p, m, l[0], ptrs[k]);

    // config B: upper half zero, Y never hits (R7), X still does (R6)
    configure(32'h00001000, 32'h00000040);
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          for (int k = 0; k < 4; k++)
            runOne(p, m, l[0], ptrs[k]);

    // R6 explicit, R7 explicit, R8 explicit
    runOne(1, 2, 1'b0, 32'h77771000);
    check("R6 X wrap", ptrOut, 32'h77771040);
    runOne(2, 2, 1'b0, 32'h00001000);
    check("R7 Y no wrap", ptrOut, 32'h00001002);
    runOne(0, 2, 1'b0, 32'h00001000);
    check("R8 single no wrap", ptrOut, 32'h00001002);

    // R9: cfg inputs changed without cfgWe, delta must remain 0x40
    @(negedge clk);
    cfgEnd = 32'h00002222; cfgDelta = 32'h00000800;
    @(negedge clk);
    runOne(1, 2, 1'b0, 32'h00001000);
    check("R9 hold", ptrOut, 32'h00001040);

    // R10: idle cycles keep ptrOut, done low
    @(negedge clk);
    ptrIn = 32'hDEADBEEF; mode = 2'b10;
    @(negedge clk);
    check("R10 hold ptr", ptrOut, 32'h00001040);
    check("R10 done low", {31'b0, ptrDone}, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule